// File: doc/BRIEF.md
# Downstream Configuration Address Translator

This block sits in a host bridge, behind the CPU's window for configuration accesses to downstream devices. Each CPU access names only 16 address bits. The block joins them under a 16-bit page value, which software holds in a mapping register outside the block. The result is a 32-bit intermediate address.

Bits [31:11] of that address form a one-hot select field. The position of its lowest set bit becomes the device number. The function and register numbers are taken from the low bits. The block then issues a type-0 configuration cycle whose address carries the bus number and an enable flag. Read data returned on that cycle goes back to the CPU one cycle after the request is accepted.

A disable control in the mapping register turns the window off. An empty select field is reported as a sticky error. In both cases no cycle is issued: writes are dropped, and reads complete with all ones over the access width. Whenever a cycle is issued, the block pulses a strobe that clears the two received-abort bits in the bridge's own status register.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The intermediate address is {win_hi[15:0], req_addr[15:0]}: the upper half comes only from the page input, the lower half only from the CPU address.
- R2: The device number is the bit position, counted from bit 11, of the lowest set bit of intermediate bits [31:11]. If several bits are set, the lowest one wins.
- R3: An issued cycle's cfg_addr holds intermediate bits [10:8] at [10:8], bits [7:0] at [7:0], the device number at [15:11], bus_num at [23:16], zeros at [30:24] and a one at bit 31.
- R4: While win_off is high at acceptance, no cycle is issued, a write is dropped, err_flag is left unchanged, and a read returns all ones over the width. The width comes from req_size: code 0 gives 0x000000FF, code 1 gives 0x0000FFFF, codes 2 and 3 give 0xFFFFFFFF. The disable check takes priority over the empty-select check.
- R5: A read that issues a cycle returns cfg_rdata, as sampled during the cycle's valid cycle, on rsp_rdata unchanged. A write's response carries zero data.
- R6: If the window is enabled and intermediate bits [31:11] are all zero, no cycle is issued and err_flag is set in the response cycle. err_flag then stays set until reset. A read returns all ones over the width, as in R4.
- R7: abort_clr is high exactly in the cycles in which cfg_valid is high, and never during a response that issued no cycle.
- R8: req_ready is high when idle. After a request is accepted, rsp_valid is high for exactly the next cycle and req_ready is low in that cycle. cfg_valid is only ever high together with rsp_valid.
- R9: During and after reset, rsp_valid, cfg_valid, abort_clr and err_flag are low and req_ready is high.
- R10: An issued cycle forwards the access's direction on cfg_write and its size code on cfg_size. It forwards the write data on cfg_wdata for a write, and zero for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | CPU access present |
| req_ready | output | 1 | Block can accept an access |
| req_addr | input | 16 | Low CPU address bits inside the window |
| req_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| win_hi | input | 16 | Page value forming intermediate bits [31:16] |
| win_off | input | 1 | Window disable control |
| bus_num | input | 8 | Static bus number placed in the cycle address |
| rsp_valid | output | 1 | Response to the accepted access |
| rsp_rdata | output | 32 | Read data of the response |
| cfg_valid | output | 1 | Configuration cycle issued |
| cfg_addr | output | 32 | Configuration cycle address with enable in bit 31 |
| cfg_write | output | 1 | Cycle direction |
| cfg_size | output | 2 | Cycle width code |
| cfg_wdata | output | 32 | Cycle write data |
| cfg_rdata | input | 32 | Read data returned by the target |
| abort_clr | output | 1 | Strobe clearing the received-abort status bits |
| err_flag | output | 1 | Sticky empty-select error |

## Verification
Every internal fault in this block shows on the response cycle, one clock after acceptance. A wrong device priority or field slice appears as a wrong cfg_addr in that cycle. A wrong disable or error decision appears as a spurious or missing cfg_valid and abort_clr, or as a wrong all-ones mask on rsp_rdata. A lost or wrongly set error state appears on err_flag in that same cycle, and it stays visible on every later response, so the bench compares err_flag with each popped expectation.

// File: rtl/cax_pkg.sv
// Shared types and helpers for the configuration address translator.
// Assumes 32-bit data and a 16-bit CPU offset inside the window.
package cax_pkg;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 16;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_B4X = 2'd3
    } xfer_size_e;

    // All-ones data pattern restricted to the access width.
    function automatic logic [DATA_W-1:0] ones_for(input logic [1:0] sz);
        case (sz)
            SZ_B1:   ones_for = 32'h0000_00FF;
            SZ_B2:   ones_for = 32'h0000_FFFF;
            default: ones_for = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cax_sel_enc.sv
// Lowest-set-bit encoder for the one-hot select field.
// Assumes DEV_W bits can hold SEL_W-1. Output pos is 0 when the field is empty.
module cax_sel_enc #(
    parameter int SEL_W = 21,
    parameter int DEV_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    output logic [DEV_W-1:0] pos,
    output logic             empty
);
    // found[i]: some bit below i is set
    logic [SEL_W:0] found;

    assign found[0] = 1'b0;

    // Prefix chain marking where the first set bit has been passed.
    for (genvar i = 0; i < SEL_W; i++) begin : g_chain
        assign found[i+1] = found[i] | sel[i];
    end

    // Pick the single position whose bit is set with nothing below it.
    always_comb begin
        pos = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (sel[i] && !found[i]) pos = DEV_W'(i);
        end
    end

    assign empty = ~found[SEL_W];
endmodule

// File: rtl/cax_addr_build.sv
// Combinational translation of window offset plus page into a type-0
// configuration address. Assumes the select field starts at bit 11.
module cax_addr_build
    import cax_pkg::*;
#(
    parameter int SEL_LSB = 11
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [OFS_W-1:0]  page,
    input  logic [BUS_W-1:0]  bus,
    output logic [DATA_W-1:0] xaddr,
    output logic              sel_empty
);
    localparam int IA_W  = 2 * OFS_W;
    localparam int SEL_W = IA_W - SEL_LSB;
    localparam int PAD_W = DATA_W - 1 - BUS_W - DEV_W - FN_W - REG_W;

    logic [IA_W-1:0]  inter;
    logic [DEV_W-1:0] dev;

    // Intermediate address: page above, CPU offset below.
    assign inter = {page, ofs};

    cax_sel_enc #(.SEL_W(SEL_W), .DEV_W(DEV_W)) u_enc (
        .sel   (inter[IA_W-1:SEL_LSB]),
        .pos   (dev),
        .empty (sel_empty)
    );

    // Pack enable, bus, device, function and register.
    assign xaddr = {1'b1, {PAD_W{1'b0}}, bus, dev,
                    inter[REG_W+FN_W-1:REG_W], inter[REG_W-1:0]};
endmodule

// File: rtl/cax_ctrl.sv
// Handshake and response sequencing: accepts one access, presents the
// cycle and the response in the following clock. Assumes the target
// returns read data combinationally while cfg_valid is high.
module cax_ctrl
    import cax_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              win_off,
    input  logic [DATA_W-1:0] xaddr,
    input  logic              sel_empty,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cfg_valid,
    output logic [DATA_W-1:0] cfg_addr,
    output logic              cfg_write,
    output logic [1:0]        cfg_size,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_rdata,
    output logic              abort_clr,
    output logic              err_flag
);
    logic              pend_q;
    logic              issue_q;
    logic              rd_q;
    logic [DATA_W-1:0] mask_q;
    logic              accept;
    logic              issue;

    assign accept = req_valid & req_ready;
    assign issue  = accept & ~win_off & ~sel_empty;

    // Response slot: one cycle after every accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            issue_q <= 1'b0;
            rd_q    <= 1'b0;
            mask_q  <= '0;
        end else begin
            pend_q  <= accept;
            issue_q <= issue;
            if (accept) begin
                rd_q   <= ~req_write;
                mask_q <= ones_for(req_size);
            end
        end
    end

    // Cycle attributes captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr  <= '0;
            cfg_write <= 1'b0;
            cfg_size  <= SZ_B1;
            cfg_wdata <= '0;
        end else if (issue) begin
            cfg_addr  <= xaddr;
            cfg_write <= req_write;
            cfg_size  <= req_size;
            cfg_wdata <= req_write ? req_wdata : '0;
        end
    end

    // Sticky error: empty select on an enabled window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err_flag <= 1'b0;
        else if (accept && !win_off && sel_empty)     err_flag <= 1'b1;
    end

    assign req_ready = ~pend_q;
    assign rsp_valid = pend_q;
    assign cfg_valid = issue_q;
    assign abort_clr = issue_q;

    // Read data: target data on issued reads, width-masked ones otherwise.
    always_comb begin
        rsp_rdata = '0;
        if (pend_q && rd_q) rsp_rdata = issue_q ? cfg_rdata : mask_q;
    end
endmodule

// File: rtl/cfg_addr_xlate.sv
// Top level: downstream configuration window to type-0 cycle translator.
// Assumes bus_num, win_hi and win_off are stable around each access.
module cfg_addr_xlate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_write,
    input  logic [31:0] req_wdata,
    input  logic [15:0] win_hi,
    input  logic        win_off,
    input  logic [7:0]  bus_num,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        cfg_valid,
    output logic [31:0] cfg_addr,
    output logic        cfg_write,
    output logic [1:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic [31:0] cfg_rdata,
    output logic        abort_clr,
    output logic        err_flag
);
    logic [31:0] xaddr;
    logic        sel_empty;

    cax_addr_build #(.SEL_LSB(11)) u_build (
        .ofs       (req_addr),
        .page      (win_hi),
        .bus       (bus_num),
        .xaddr     (xaddr),
        .sel_empty (sel_empty)
    );

    cax_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_size  (req_size),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .win_off   (win_off),
        .xaddr     (xaddr),
        .sel_empty (sel_empty),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .cfg_valid (cfg_valid),
        .cfg_addr  (cfg_addr),
        .cfg_write (cfg_write),
        .cfg_size  (cfg_size),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .abort_clr (abort_clr),
        .err_flag  (err_flag)
    );
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
// Port-level properties of the translator, bound to the top module.
module cfg_addr_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_addr,
    input logic [15:0] win_hi,
    input logic        win_off,
    input logic        rsp_valid,
    input logic        cfg_valid,
    input logic [31:0] cfg_addr,
    input logic        abort_clr,
    input logic        err_flag
);
    a_r8_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    a_r8_busy_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r8_cycle_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> rsp_valid);
    a_r4_off_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && win_off) |=> !cfg_valid && !abort_clr);
    a_r6_empty_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !win_off && {win_hi, req_addr[15:11]} == 21'd0)
        |=> (err_flag && !cfg_valid));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    a_r7_clr_matches: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr == cfg_valid);
    a_r3_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0));
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .win_hi    (win_hi),
    .win_off   (win_off),
    .rsp_valid (rsp_valid),
    .cfg_valid (cfg_valid),
    .cfg_addr  (cfg_addr),
    .abort_clr (abort_clr),
    .err_flag  (err_flag)
);

// File: tb/cfg_addr_xlate_bench.sv
// Scoreboard bench: the driver pushes expectations, the monitor pops and compares them.
module cfg_addr_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [15:0] win_hi = '0;
    logic        win_off = 1'b0;
    logic [7:0]  bus_num = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        cfg_valid;
    logic [31:0] cfg_addr;
    logic        cfg_write;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        abort_clr;
    logic        err_flag;

    localparam logic [31:0] RD_KEY = 32'h5A00_C3C3;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic        issue;
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        err;
    } exp_t;

    exp_t sb[$];
    logic model_err = 1'b0;

    always #4 clk = ~clk;

    // Target model: read data derived from the cycle address.
    assign cfg_rdata = cfg_valid ? (cfg_addr ^ RD_KEY) : 32'hDEAD_BEEF;

    cfg_addr_xlate u_cfg_addr_xlate (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_for(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // Driver: computes the expectation from the requirements and issues the access.
    task automatic access(input string tag, input logic [15:0] a, input logic [15:0] hi,
                          input logic off, input logic wr, input logic [1:0] sz,
                          input logic [31:0] wd);
        exp_t e;
        logic [31:0] inter;
        logic [20:0] sel;
        int dev;
        inter = {hi, a};
        sel = inter[31:11];
        dev = 0;
        for (int i = 20; i >= 0; i--) if (sel[i]) dev = i;
        e.tag   = tag;
        e.issue = !off && (sel != 0);
        e.addr  = 32'h8000_0000 | (32'(bus_num) << 16) | (32'(dev) << 11) | {24'd0, inter[7:0]}
                  | {21'd0, inter[10:8], 8'd0};
        e.wr    = wr;
        e.sz    = sz;
        e.wdata = wr ? wd : 32'd0;
        if (!off && sel == 0) model_err = 1'b1;
        e.err   = model_err;
        e.rdata = wr ? 32'd0 : (e.issue ? (e.addr ^ RD_KEY) : mask_for(sz));
        sb.push_back(e);
        @(negedge clk);
        req_addr = a; win_hi = hi; win_off = off; req_write = wr; req_size = sz;
        req_wdata = wd; req_valid = 1'b1;
        check({tag, " R8 ready idle"}, 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R8 busy in rsp"}, 32'(req_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 single rsp"}, 32'(rsp_valid), 32'd0);
    endtask

    // Monitor: pops one expectation per response cycle.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected rsp", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R4 R6 cycle issued"}, 32'(cfg_valid), 32'(e.issue));
                check({e.tag, " R7 abort clear"}, 32'(abort_clr), 32'(e.issue));
                check({e.tag, " R6 err flag"}, 32'(err_flag), 32'(e.err));
                check({e.tag, " R5 rsp data"}, rsp_rdata, e.rdata);
                if (e.issue) begin
                    check({e.tag, " R1 R2 R3 cfg addr"}, cfg_addr, e.addr);
                    check({e.tag, " R10 write"}, 32'(cfg_write), 32'(e.wr));
                    check({e.tag, " R10 size"}, 32'(cfg_size), 32'(e.sz));
                    check({e.tag, " R10 wdata"}, cfg_wdata, e.wdata);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9 cfg_valid", 32'(cfg_valid), 32'd0);
        check("R9 abort_clr", 32'(abort_clr), 32'd0);
        check("R9 err_flag", 32'(err_flag), 32'd0);
        check("R9 ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 page bit selects device 6, function 5, register 08
        access("R1 page sel", 16'h0508, 16'h0002, 1'b0, 1'b0, 2'd2, 32'd0);
        // R2 select bit from CPU offset, 2-byte write
        access("R2 ofs sel", 16'h8304, 16'h0000, 1'b0, 1'b1, 2'd1, 32'h1234_ABCD);
        // R2 several bits: lowest wins
        access("R2 multi", 16'h30FC, 16'h00F0, 1'b0, 1'b0, 2'd0, 32'd0);
        // R2 top select bit gives device 20
        access("R2 top", 16'h0001, 16'h8000, 1'b0, 1'b1, 2'd3, 32'hCAFE_0001);
        // R3 bus number placement
        bus_num = 8'h5A;
        access("R3 bus", 16'h0FFF, 16'h0000, 1'b0, 1'b0, 2'd2, 32'd0);
        // R4 disabled reads of each width and a dropped write
        access("R4 off b1", 16'h0800, 16'h0000, 1'b1, 1'b0, 2'd0, 32'd0);
        access("R4 off b2", 16'h0800, 16'h0000, 1'b1, 1'b0, 2'd1, 32'd0);
        access("R4 off b4x", 16'h0800, 16'h0000, 1'b1, 1'b0, 2'd3, 32'd0);
        access("R4 off wr", 16'h0800, 16'h0000, 1'b1, 1'b1, 2'd2, 32'hFFFF_0000);
        // R4 disable takes priority over empty select: no error
        access("R4 off empty", 16'h07FC, 16'h0000, 1'b1, 1'b0, 2'd2, 32'd0);
        // R6 empty select: error, masked ones
        access("R6 empty rd", 16'h07FC, 16'h0000, 1'b0, 1'b0, 2'd1, 32'd0);
        access("R6 empty wr", 16'h0004, 16'h0000, 1'b0, 1'b1, 2'd2, 32'h0BAD_0BAD);
        // R6 flag sticky across a good access
        access("R6 sticky", 16'h1010, 16'h0400, 1'b0, 1'b0, 2'd2, 32'd0);
        done = 1;
        check("R8 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule